// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control of a successive-approximation converter. A start strike latches a set of conversion settings: resolution, sample length, single or continuous operation, clock source and divide ratio. It then runs a preparation phase counted in bus cycles, a sample phase and a bit-by-bit approximation phase, both counted in conversion-clock cycles. The conversion clock is not a separate clock net. It is a one-cycle enable derived from the bus clock, or from an externally synchronised asynchronous tick, and then divided by 1, 2, 4 or 8.

During the approximation phase the block drives a trial code to the analog side. A single comparator bit answers it, stating whether the input is at or above the trial. The result registers are written once, at the end of the last approximation cycle, and a sticky completion flag is raised at the same time. A read strobe clears the flag. In continuous mode the next conversion starts straight away and skips the preparation phase. A new start at any moment abandons the running conversion and begins again with the new settings.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, `res_hi`/`res_lo` are 0 and `dac_code` is 0.
- R2: A start sampled at edge E, with the bus source and ratio 1, completes (sets `done`) at edge E+5+T. T is the first-conversion count: 20 for 8-bit short, 23 for 10/12-bit short, 40 for 8-bit long, 43 for 10/12-bit long. `res_sel` encoding: 00 = 8-bit, 01 = 10-bit, 10 and 11 = 12-bit.
- R3: With `cont_en` latched at 1, each later completion follows the previous one by S conversion-clock cycles with no preparation phase. S is 17 (8-bit short), 20 (10/12-bit short), 37 (8-bit long) or 40 (10/12-bit long).
- R4: The conversion clock fires on every 2^`div_sel`-th source tick, so every conversion-clock count above is multiplied by 1, 2, 4 or 8.
- R5: With `async_sel`=1, the source ticks are the cycles in which `async_tick` is high, and the first conversion of a run adds ASYNC_WAIT_CYC bus cycles to the preparation phase. Later continuous conversions do not add it.
- R6: The result equals the comparator-resolved code, found MSB first at one bit per conversion-clock cycle. It is right-justified: `res_hi` holds bits 11:8 and `res_lo` holds bits 7:0, with unused upper bits zero.
- R7: `res_hi`/`res_lo` change only at a completion edge.
- R8: `done` is set at every completion and cleared by `rd_ack`. If both fall in the same edge, `done` ends up set.
- R9: A start while busy aborts the running conversion and restarts with the new settings. A start in the completion edge discards that completion: the results and `done` stay as they were.
- R10: `busy` is high from the edge after a start until the last completion of a single conversion, and stays high through a continuous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strike, latches the settings |
| res_sel | input | 2 | Resolution select |
| long_smp | input | 1 | Long sample enable |
| cont_en | input | 1 | Continuous conversion enable |
| async_sel | input | 1 | 1 selects the asynchronous tick as source |
| div_sel | input | 2 | Divide ratio exponent |
| async_tick | input | 1 | Synchronised asynchronous clock enable |
| cmp_hi | input | 1 | Comparator: input at or above `dac_code` |
| rd_ack | input | 1 | Result read strobe, clears `done` |
| dac_code | output | 12 | Trial code during approximation, else 0 |
| res_hi | output | 4 | Result bits 11:8 |
| res_lo | output | 8 | Result bits 7:0 |
| done | output | 1 | Completion flag |
| busy | output | 1 | Conversion in progress |

## Verification
Two pairs of events can meet in one edge: a completion with a result read, and a completion with a fresh start. The bench counts cycles from a start to place `rd_ack` exactly on the completion edge and expects `done` to stay set with the new result. In a second run it places a new start on that edge and expects the old result, a clear flag and a full new latency counted from the restart. A behavioural model that counts preparation cycles and source ticks is compared with the outputs every cycle through both collisions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W         = 12;
    localparam int CNT_W         = 6;
    localparam int BIT_IDX_W     = 4;
    localparam int PREP_BUS_CYC  = 5;
    localparam int BASE_SUB_8    = 17;
    localparam int BASE_SUB_WIDE = 20;
    localparam int LONG_EXTRA    = 20;
    localparam int FIRST_EXTRA   = 3;

    localparam logic [1:0] RES_SEL_8  = 2'b00;
    localparam logic [1:0] RES_SEL_10 = 2'b01;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PREP,
        PH_SAMPLE,
        PH_CONV
    } phase_t;

    typedef struct packed {
        logic [1:0] res;
        logic       long_smp;
        logic       cont;
        logic       async_src;
        logic [1:0] div;
    } conv_cfg_t;

    typedef struct packed {
        logic [3:0] hi;
        logic [7:0] lo;
    } result_t;

    function automatic logic [BIT_IDX_W-1:0] res_bits(input logic [1:0] res);
        if (res == RES_SEL_8)       return BIT_IDX_W'(8);
        else if (res == RES_SEL_10) return BIT_IDX_W'(10);
        else                        return BIT_IDX_W'(12);
    endfunction

    function automatic logic [CNT_W-1:0] adck_total(input logic [1:0] res,
                                                    input logic       lng,
                                                    input logic       first);
        logic [CNT_W-1:0] n;
        n = (res == RES_SEL_8) ? CNT_W'(BASE_SUB_8) : CNT_W'(BASE_SUB_WIDE);
        if (lng)   n = n + CNT_W'(LONG_EXTRA);
        if (first) n = n + CNT_W'(FIRST_EXTRA);
        return n;
    endfunction

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen
    import adc_seq_pkg::*;
#(
    parameter int DIV_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 async_src,
    input  logic                 async_tick,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 ck_tick
);
    localparam int CW = (1 << DIV_SEL_W) - 1;

    logic [CW-1:0] div_cnt;
    logic [CW:0]   ratio;
    logic [CW-1:0] div_last;
    logic          src_tick;

    assign src_tick = async_src ? async_tick : 1'b1;
    assign ratio    = (CW+1)'(1) << div_sel;
    assign div_last = CW'(ratio - (CW+1)'(1));
    assign ck_tick  = run && src_tick && (div_cnt == div_last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
        end else if (src_tick) begin
            div_cnt <= (div_cnt == div_last) ? '0 : div_cnt + CW'(1);
        end
    end

    // R4: the divider count never passes the selected ratio
    a_r4_div_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (div_cnt <= div_last));

endmodule

// File: rtl/adc_phase_ctl.sv
module adc_phase_ctl
    import adc_seq_pkg::*;
#(
    parameter int ASYNC_WAIT_CYC = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  conv_cfg_t            cfg_in,
    input  logic                 ck_tick,
    output conv_cfg_t            cfg,
    output logic                 run,
    output logic                 conv,
    output logic                 finish,
    output logic                 busy,
    output logic [BIT_IDX_W-1:0] bit_idx
);
    localparam int PW = $clog2(PREP_BUS_CYC + ASYNC_WAIT_CYC + 1);

    phase_t           phase;
    logic [PW-1:0]    prep_cnt;
    logic [CNT_W-1:0] left;
    logic [CNT_W-1:0] conv_edge;

    assign conv_edge = CNT_W'(res_bits(cfg.res)) + CNT_W'(1);
    assign run       = (phase == PH_SAMPLE) || (phase == PH_CONV);
    assign conv      = (phase == PH_CONV);
    assign busy      = (phase != PH_IDLE);
    assign bit_idx   = BIT_IDX_W'(left - CNT_W'(1));
    assign finish    = ck_tick && conv && (left == CNT_W'(1)) && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            prep_cnt <= '0;
            left     <= '0;
            cfg      <= '0;
        end else if (start) begin
            cfg      <= cfg_in;
            phase    <= PH_PREP;
            prep_cnt <= PW'(PREP_BUS_CYC - 1 + (cfg_in.async_src ? ASYNC_WAIT_CYC : 0));
        end else begin
            case (phase)
                PH_PREP: begin
                    if (prep_cnt == '0) begin
                        phase <= PH_SAMPLE;
                        left  <= adck_total(cfg.res, cfg.long_smp, 1'b1);
                    end else begin
                        prep_cnt <= prep_cnt - PW'(1);
                    end
                end
                PH_SAMPLE, PH_CONV: begin
                    if (ck_tick) begin
                        if (left == CNT_W'(1)) begin
                            if (cfg.cont) begin
                                phase <= PH_SAMPLE;
                                left  <= adck_total(cfg.res, cfg.long_smp, 1'b0);
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            left <= left - CNT_W'(1);
                            if (left == conv_edge) phase <= PH_CONV;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9: a start always restarts from the preparation phase
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase == PH_PREP));

    // R2: the conversion-clock count is never exhausted while counting
    a_r2_count_live: assert property (@(posedge clk) disable iff (rst)
        run |-> (left != '0));

    // R10: a single conversion returns to idle after its completion
    a_r10_single_idle: assert property (@(posedge clk) disable iff (rst)
        (finish && !cfg.cont) |=> (phase == PH_IDLE));

    // R3: a continuous run goes straight back to sampling
    a_r3_cont_resample: assert property (@(posedge clk) disable iff (rst)
        (finish && cfg.cont) |=> (phase == PH_SAMPLE));

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 conv,
    input  logic                 ck_tick,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    input  logic                 cmp_hi,
    input  logic                 finish,
    input  logic                 rd_ack,
    output logic [RES_W-1:0]     dac_code,
    output result_t              result,
    output logic                 done
);
    logic [RES_W-1:0] sar;
    logic [RES_W-1:0] trial_bit;

    assign trial_bit = RES_W'(1) << bit_idx;
    assign dac_code  = conv ? (sar | trial_bit) : '0;

    always_ff @(posedge clk) begin
        if (rst || !conv) begin
            sar <= '0;
        end else if (ck_tick && cmp_hi) begin
            sar <= sar | trial_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (finish) begin
            result <= result_t'(sar | (cmp_hi ? trial_bit : '0));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         done <= 1'b0;
        else if (finish) done <= 1'b1;
        else if (rd_ack) done <= 1'b0;
    end

    // R7: result registers hold between completions
    a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(result));

    // R8: completion sets the flag even with a read in the same edge
    a_r8_done_set: assert property (@(posedge clk) disable iff (rst)
        finish |=> done);

    // R8: a read without completion clears the flag
    a_r8_done_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !finish) |=> !done);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int ASYNC_WAIT_CYC = 40,
    parameter int DIV_SEL_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           res_sel,
    input  logic                 long_smp,
    input  logic                 cont_en,
    input  logic                 async_sel,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 async_tick,
    input  logic                 cmp_hi,
    input  logic                 rd_ack,
    output logic [RES_W-1:0]     dac_code,
    output logic [3:0]           res_hi,
    output logic [7:0]           res_lo,
    output logic                 done,
    output logic                 busy
);
    conv_cfg_t            cfg_in;
    conv_cfg_t            cfg;
    logic                 run;
    logic                 conv;
    logic                 finish;
    logic                 ck_tick;
    logic [BIT_IDX_W-1:0] bit_idx;
    result_t              result;

    always_comb begin
        cfg_in.res       = res_sel;
        cfg_in.long_smp  = long_smp;
        cfg_in.cont      = cont_en;
        cfg_in.async_src = async_sel;
        cfg_in.div       = 2'(div_sel);
    end

    adc_clk_gen #(.DIV_SEL_W(2)) u_clk_gen (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .async_src  (cfg.async_src),
        .async_tick (async_tick),
        .div_sel    (cfg.div),
        .ck_tick    (ck_tick)
    );

    adc_phase_ctl #(.ASYNC_WAIT_CYC(ASYNC_WAIT_CYC)) u_phase_ctl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cfg_in  (cfg_in),
        .ck_tick (ck_tick),
        .cfg     (cfg),
        .run     (run),
        .conv    (conv),
        .finish  (finish),
        .busy    (busy),
        .bit_idx (bit_idx)
    );

    adc_sar_core u_sar_core (
        .clk      (clk),
        .rst      (rst),
        .conv     (conv),
        .ck_tick  (ck_tick),
        .bit_idx  (bit_idx),
        .cmp_hi   (cmp_hi),
        .finish   (finish),
        .rd_ack   (rd_ack),
        .dac_code (dac_code),
        .result   (result),
        .done     (done)
    );

    assign res_hi = result.hi;
    assign res_lo = result.lo;

endmodule

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
    localparam int WAIT = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  res_sel = 2'b00;
    logic        long_smp = 1'b0;
    logic        cont_en = 1'b0;
    logic        async_sel = 1'b0;
    logic [1:0]  div_sel = 2'b00;
    logic        async_tick = 1'b1;
    logic        cmp_hi;
    logic        rd_ack = 1'b0;
    logic [11:0] dac_code;
    logic [3:0]  res_hi;
    logic [7:0]  res_lo;
    logic        done;
    logic        busy;

    logic [11:0] vin = 12'hA5C;
    logic [11:0] vin_scaled;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          async_mode = 0;
    int          acnt = 0;
    bit          ended = 0;

    // behavioural reference state
    int          m_busy = 0, m_done = 0, m_hi = 0, m_lo = 0;
    int          m_wait = 0, m_ticks = 0, m_need = 0, m_ratio = 1;
    int          m_res = 0, m_long = 0, m_cont = 0, m_async = 0, m_shift = 4;
    logic [11:0] m_exp;

    always #5 clk = ~clk;

    adc_conv_seq #(.ASYNC_WAIT_CYC(WAIT)) u_adc_conv_seq (
        .clk(clk), .rst(rst), .start(start), .res_sel(res_sel),
        .long_smp(long_smp), .cont_en(cont_en), .async_sel(async_sel),
        .div_sel(div_sel), .async_tick(async_tick), .cmp_hi(cmp_hi),
        .rd_ack(rd_ack), .dac_code(dac_code), .res_hi(res_hi),
        .res_lo(res_lo), .done(done), .busy(busy)
    );

    // behavioural comparator on the latched resolution
    always_comb vin_scaled = vin >> m_shift;
    assign cmp_hi = (vin_scaled >= dac_code);

    function automatic int shift_of(input int r);
        if (r == 0) return 4;
        if (r == 1) return 2;
        return 0;
    endfunction

    // conversion-clock counts from R2 and R3
    function automatic int adck_count(input int r, input int lng, input int first);
        case ({r == 0, lng != 0, first != 0})
            3'b101:  return 20;
            3'b001:  return 23;
            3'b111:  return 40;
            3'b011:  return 43;
            3'b100:  return 17;
            3'b000:  return 20;
            3'b110:  return 37;
            default: return 40;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_hi = 0; m_lo = 0; m_wait = 0; m_ticks = 0;
        end else begin
            bit fin_now;
            fin_now = 0;
            if (start) begin
                m_res = int'(res_sel); m_long = int'(long_smp); m_cont = int'(cont_en);
                m_async = int'(async_sel); m_ratio = 1 << div_sel; m_shift = shift_of(m_res);
                m_busy = 1; m_ticks = 0;
                m_wait = 5 + (async_sel ? WAIT : 0);
                m_need = adck_count(m_res, m_long, 1) * m_ratio;
            end else if (m_busy != 0) begin
                if (m_wait > 0) m_wait--;
                else begin
                    if (m_async == 0 || async_tick) m_ticks++;
                    if (m_ticks == m_need) begin
                        fin_now = 1;
                        if (m_cont != 0) begin
                            m_ticks = 0;
                            m_need = adck_count(m_res, m_long, 0) * m_ratio;
                        end else m_busy = 0;
                    end
                end
            end
            if (fin_now) begin
                m_exp = vin >> m_shift;
                m_hi = int'(m_exp[11:8]); m_lo = int'(m_exp[7:0]); m_done = 1;
            end else if (rd_ack) m_done = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !ended) begin
            check("R8", "done vs model", int'(done), m_done);
            check("R10", "busy vs model", int'(busy), m_busy);
            check("R7", "res_hi vs model", int'(res_hi), m_hi);
            check("R7", "res_lo vs model", int'(res_lo), m_lo);
        end
    end

    always @(negedge clk) begin
        acnt++;
        if (async_mode == 0) async_tick = 1'b1;
        else async_tick = ((acnt % 3) == 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic issue(input int r, input int lng, input int cnt, input int asy, input int dv);
        res_sel = 2'(r); long_smp = lng[0]; cont_en = cnt[0]; async_sel = asy[0]; div_sel = 2'(dv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure_next(output int n);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        n = 1;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic clear_done();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    initial begin
        int n;
        int expv;
        int old_hi, old_lo;
        repeat (3) @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "result after reset", int'({res_hi, res_lo}), 0);
        check("R1", "dac_code after reset", int'(dac_code), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 / R6: every resolution and sample length, bus source, ratio 1
        for (int r = 0; r < 3; r++) begin
            for (int l = 0; l < 2; l++) begin
                vin = 12'(12'hA5C + r * 12'h111 + l * 12'h0F3);
                issue(r, l, 0, 0, 0);
                measure(n);
                check("R2", "first latency", n, 5 + adck_count(r, l, 1));
                expv = int'(vin) >> shift_of(r);
                check("R6", "res_hi", int'(res_hi), (expv >> 8) & 15);
                check("R6", "res_lo", int'(res_lo), expv & 255);
                clear_done();
            end
        end

        // R4: divide ratios on a 10-bit short conversion
        for (int d = 1; d < 4; d++) begin
            vin = 12'h3C7;
            issue(1, 0, 0, 0, d);
            measure(n);
            check("R4", "divided latency", n, 5 + 23 * (1 << d));
            clear_done();
        end

        // R5: asynchronous source held active adds the startup wait
        issue(0, 0, 0, 1, 0);
        measure(n);
        check("R5", "async first latency", n, 5 + WAIT + 20);
        clear_done();

        // R5: sparse asynchronous ticks, judged by the model every cycle
        async_mode = 1;
        vin = 12'h8E1;
        issue(0, 0, 0, 1, 1);
        measure(n);
        check("R5", "sparse async completes", int'(done), 1);
        check("R6", "sparse async 8-bit result", int'({res_hi, res_lo}), 12'h8E1 >> 4);
        clear_done();
        async_mode = 0;

        // R3: continuous 12-bit long, ratio 2
        vin = 12'h5A3;
        issue(2, 1, 1, 0, 1);
        measure(n);
        check("R3", "continuous first latency", n, 5 + 43 * 2);
        measure_next(n);
        check("R3", "continuous interval", n, 40 * 2);
        measure_next(n);
        check("R3", "continuous interval again", n, 40 * 2);
        check("R10", "busy during run", int'(busy), 1);

        // R9: abort the continuous run with a single 8-bit short conversion
        old_hi = int'(res_hi); old_lo = int'(res_lo);
        clear_done();
        issue(0, 0, 0, 0, 0);
        check("R9", "result kept on abort", int'({res_hi, res_lo}), (old_hi << 8) | old_lo);
        measure(n);
        check("R9", "restart latency", n - 1 + 1, 5 + 20 - 1 + 1);
        clear_done();

        // R3 / R5: continuous asynchronous run drops the wait after the first
        issue(1, 0, 1, 1, 0);
        measure(n);
        check("R5", "async continuous first", n, 5 + WAIT + 23);
        measure_next(n);
        check("R5", "async continuous interval", n, 20);
        issue(1, 0, 0, 0, 0);
        measure(n);
        clear_done();
        @(negedge clk);

        // R8: read strobe lands on the completion edge while done is set
        issue(0, 0, 0, 0, 0);
        measure(n);
        vin = 12'hC30;
        issue(0, 0, 0, 0, 0);
        repeat (24) @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        check("R8", "done survives same-edge read", int'(done), 1);
        check("R8", "new result stored", int'(res_lo), 8'hC3);
        clear_done();

        // R9: a start on the completion edge discards that completion
        old_hi = int'(res_hi); old_lo = int'(res_lo);
        vin = 12'h777;
        issue(0, 0, 0, 0, 0);
        repeat (24) @(negedge clk);
        issue(1, 0, 0, 0, 0);
        check("R9", "done stays clear", int'(done), 0);
        check("R9", "result unchanged", int'({res_hi, res_lo}), (old_hi << 8) | old_lo);
        check("R10", "busy after restart", int'(busy), 1);
        measure(n);
        check("R9", "latency from restart", n, 5 + 23);
        check("R6", "10-bit result", int'({res_hi, res_lo}), 12'h777 >> 2);
        clear_done();
        repeat (3) @(negedge clk);

        ended = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule